// File: doc/BRIEF.md
# Sector Line-Pair Fill Sequencer

This block turns cache misses into ordered burst-read commands for the external bus. The cache groups two 32-byte lines into one sector. A miss raised by the hardware miss handler produces two fills. The line that was asked for goes out first. The other line of the same sector, called the companion line, follows. A software prefetch request produces one fill for its own line and nothing more.

The companion fill is optional and has low priority. It may be pipelined behind the demand burst when the bus has signalled, through its next-address input, that a new cycle may start early. Otherwise it waits until the demand burst has finished. It also waits while any of these is true:
- demand data traffic of higher priority is pending;
- the bus asks for an address hold;
- the bus asks for a back-off.

It is dropped when the cache reports that the companion line is already present, or when a new miss arrives before it has been issued. The bus side is a valid/ready request channel carrying a line-aligned address and a pipelined flag. The bus reports each finished burst with a completion strobe, and the block passes that strobe on as a fill-done pulse.

Top module: `sector_prefetch_seq`

## Requirements
- R1: After reset, `req_valid` and `fill_done` are 0 and `miss_ready` is 1.
- R2: The first request after an accepted miss carries the miss address with bits [4:0] cleared and `req_pipelined` = 0. Every request address has bits [4:0] equal to 0.
- R3: For a hardware miss (`miss_sw` = 0), after the demand burst completes, a second request is made for the companion line. Its address is the demand line address with bit 5 inverted.
- R4: For a software prefetch (`miss_sw` = 1), only one request is made, and the block returns to accepting misses after that burst completes.
- R5: While `addr_hold` or `backoff` is 1, `req_valid` is 0.
- R6: While `hi_prio_pending` is 1, no companion request is presented. The demand request is not affected by it.
- R7: If `next_addr` was sampled 1 in a cycle while the demand burst was outstanding, the companion request is presented in the following cycle, before the demand burst completes, with `req_pipelined` = 1.
- R8: If `next_addr` has not been sampled 1, no companion request is presented while the demand burst is outstanding.
- R9: `probe_addr` shows the companion line address. If `companion_hit` is 1 while the companion is pending, no request is made and the companion is dropped.
- R10: A new miss offered while the companion waits to be issued is accepted at once. The companion is dropped, and the next request is the new miss's demand line.
- R11: `fill_done` pulses for one cycle for each completed burst. `fill_companion` is 0 for the demand fill and 1 for the companion fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_valid | input | 1 | Miss or prefetch request offered |
| miss_addr | input | ADDR_W | Byte address of the missing line |
| miss_sw | input | 1 | 1 = software prefetch (single line), 0 = hardware miss (line pair) |
| miss_ready | output | 1 | Miss accepted this cycle when high with miss_valid |
| hi_prio_pending | input | 1 | Higher-priority data read or write waiting |
| companion_hit | input | 1 | Cache reports the line at probe_addr is present |
| probe_addr | output | ADDR_W | Companion line address for the cache lookup |
| addr_hold | input | 1 | Bus address hold active |
| backoff | input | 1 | Bus back-off active |
| next_addr | input | 1 | Bus allows the next cycle to start early |
| req_valid | output | 1 | Burst-read request valid |
| req_ready | input | 1 | Bus accepts the request |
| req_addr | output | ADDR_W | Line-aligned burst address |
| req_pipelined | output | 1 | Request issued while the previous burst is still running |
| burst_done | input | 1 | Bus reports one burst finished |
| fill_done | output | 1 | One-cycle pulse per completed fill |
| fill_companion | output | 1 | The completed fill was the companion line |

## Verification
Five properties are checked on every cycle:
- every request is line-aligned;
- no request appears under address hold or back-off;
- the companion never shows while higher-priority traffic is pending or the line is reported present;
- a pipelined request is always a companion;
- accepting a miss never coincides with a request.

Ordering cannot be judged one cycle at a time, so only the bench scenarios can show it. That covers demand before companion, the single fill of a software prefetch, the early companion that follows a sampled next-address, and the switch to a new miss that drops a waiting companion.

// File: rtl/spf_pkg.sv
// Package: shared state encoding for the sector fill sequencer.
// Assumes: nothing beyond the importing module using these names.
package spf_pkg;
    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,  // waiting for a miss
        S_REQ_D   = 3'd1,  // presenting the demand request
        S_WAIT_D  = 3'd2,  // demand burst outstanding
        S_WAIT_DC = 3'd3,  // demand and pipelined companion outstanding
        S_REQ_C   = 3'd4,  // presenting the companion request
        S_WAIT_C  = 3'd5   // companion burst outstanding
    } spf_state_t;
endpackage

// File: rtl/spf_line_addr.sv
// Module: derives the line-aligned demand address and the companion
// (other half of the sector) address from a raw byte address.
// Assumes: LINE_BYTES is a power of two, and a sector is two lines.
module spf_line_addr #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32
) (
    input  logic [ADDR_W-1:0] raw_addr,
    output logic [ADDR_W-1:0] dem_line,
    output logic [ADDR_W-1:0] comp_line
);
    localparam int OFS_W = $clog2(LINE_BYTES);
    localparam logic [ADDR_W-1:0] OFS_MASK = ADDR_W'(LINE_BYTES - 1);
    localparam logic [ADDR_W-1:0] SEL_BIT  = ADDR_W'(1) << OFS_W;

    // Clear the in-line offset; flip the line-select bit for the companion.
    always_comb begin
        dem_line  = raw_addr & ~OFS_MASK;
        comp_line = dem_line ^ SEL_BIT;
    end
endmodule

// File: rtl/spf_issue_gate.sv
// Module: decides whether a demand or a companion request may be shown.
// Assumes: all inputs are already synchronous to the block clock.
module spf_issue_gate (
    input  logic addr_hold,
    input  logic backoff,
    input  logic hi_prio_pending,
    input  logic companion_hit,
    input  logic new_miss,
    output logic dem_ok,
    output logic comp_ok
);
    logic bus_free;

    // Bus holds stop all requests; the companion also yields to demand work.
    always_comb begin
        bus_free = !(addr_hold || backoff);
        dem_ok   = bus_free;
        comp_ok  = bus_free && !hi_prio_pending && !companion_hit && !new_miss;
    end
endmodule

// File: rtl/spf_seq_fsm.sv
// Module: ordering state machine. It issues the demand line, then the
// companion for hardware misses, either pipelined (next-address seen) or
// after the demand burst. It drops the companion on a hit or a new miss.
// Assumes: the bus returns one burst_done per accepted request, in order.
module spf_seq_fsm #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    input  logic              miss_sw,
    input  logic [ADDR_W-1:0] dem_line,
    input  logic [ADDR_W-1:0] comp_line,
    input  logic              dem_ok,
    input  logic              comp_ok,
    input  logic              companion_hit,
    input  logic              next_addr,
    input  logic              req_ready,
    input  logic              burst_done,
    output logic              miss_ready,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    output logic              req_pipelined,
    output logic              comp_sel,
    output logic              fill_done,
    output logic              fill_companion,
    output logic [ADDR_W-1:0] probe_addr
);
    import spf_pkg::*;

    spf_state_t        state, nxt;
    logic [ADDR_W-1:0] dem_q, comp_q;
    logic              have_comp, na_q, issued;

    // Next-state and output decode.
    always_comb begin
        nxt            = state;
        miss_ready     = 1'b0;
        req_valid      = 1'b0;
        req_addr       = dem_q;
        req_pipelined  = 1'b0;
        comp_sel       = 1'b0;
        fill_done      = 1'b0;
        fill_companion = 1'b0;
        issued         = 1'b0;
        case (state)
            S_IDLE: begin
                miss_ready = 1'b1;
                if (miss_valid) nxt = S_REQ_D;
            end
            S_REQ_D: begin
                req_valid = dem_ok;
                if (dem_ok && req_ready) nxt = S_WAIT_D;
            end
            S_WAIT_D: begin
                if (have_comp && na_q) begin
                    comp_sel      = 1'b1;
                    req_addr      = comp_q;
                    req_pipelined = 1'b1;
                    req_valid     = comp_ok;
                    issued        = comp_ok && req_ready;
                end
                fill_done = burst_done;
                if (burst_done) begin
                    if (issued)                          nxt = S_WAIT_C;
                    else if (have_comp && !companion_hit) nxt = S_REQ_C;
                    else                                 nxt = S_IDLE;
                end else if (issued) begin
                    nxt = S_WAIT_DC;
                end
            end
            S_WAIT_DC: begin
                fill_done = burst_done;
                if (burst_done) nxt = S_WAIT_C;
            end
            S_REQ_C: begin
                miss_ready = 1'b1;
                comp_sel   = 1'b1;
                req_addr   = comp_q;
                req_valid  = comp_ok;
                if (miss_valid)                nxt = S_REQ_D;
                else if (companion_hit)        nxt = S_IDLE;
                else if (comp_ok && req_ready) nxt = S_WAIT_C;
            end
            S_WAIT_C: begin
                fill_done      = burst_done;
                fill_companion = 1'b1;
                if (burst_done) nxt = S_IDLE;
            end
            default: nxt = S_IDLE;
        endcase
    end

    // State, captured addresses, companion flag and sampled next-address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            dem_q     <= '0;
            comp_q    <= '0;
            have_comp <= 1'b0;
            na_q      <= 1'b0;
        end else begin
            state <= nxt;
            na_q  <= (state == S_WAIT_D) && next_addr;
            if (miss_valid && miss_ready) begin
                dem_q     <= dem_line;
                comp_q    <= comp_line;
                have_comp <= !miss_sw;
            end else if (state == S_WAIT_D && companion_hit) begin
                have_comp <= 1'b0;
            end
        end
    end

    assign probe_addr = comp_q;
endmodule

// File: rtl/sector_prefetch_seq.sv
// Module: top of the sector fill sequencer. It connects address
// derivation, the issue gate and the ordering state machine.
// Assumes: a sector is two lines of LINE_BYTES, and the reset is
// synchronous and active low.
module sector_prefetch_seq #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    input  logic [ADDR_W-1:0] miss_addr,
    input  logic              miss_sw,
    output logic              miss_ready,
    input  logic              hi_prio_pending,
    input  logic              companion_hit,
    output logic [ADDR_W-1:0] probe_addr,
    input  logic              addr_hold,
    input  logic              backoff,
    input  logic              next_addr,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    output logic              req_pipelined,
    input  logic              burst_done,
    output logic              fill_done,
    output logic              fill_companion
);
    logic [ADDR_W-1:0] dem_line, comp_line;
    logic              dem_ok, comp_ok, comp_sel;

    spf_line_addr #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_addr (
        .raw_addr (miss_addr),
        .dem_line (dem_line),
        .comp_line(comp_line)
    );

    spf_issue_gate u_gate (
        .addr_hold      (addr_hold),
        .backoff        (backoff),
        .hi_prio_pending(hi_prio_pending),
        .companion_hit  (companion_hit),
        .new_miss       (miss_valid),
        .dem_ok         (dem_ok),
        .comp_ok        (comp_ok)
    );

    spf_seq_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .miss_valid    (miss_valid),
        .miss_sw       (miss_sw),
        .dem_line      (dem_line),
        .comp_line     (comp_line),
        .dem_ok        (dem_ok),
        .comp_ok       (comp_ok),
        .companion_hit (companion_hit),
        .next_addr     (next_addr),
        .req_ready     (req_ready),
        .burst_done    (burst_done),
        .miss_ready    (miss_ready),
        .req_valid     (req_valid),
        .req_addr      (req_addr),
        .req_pipelined (req_pipelined),
        .comp_sel      (comp_sel),
        .fill_done     (fill_done),
        .fill_companion(fill_companion),
        .probe_addr    (probe_addr)
    );
endmodule

// File: rtl/sector_prefetch_seq_chk.sv
// Module: cycle-by-cycle property checker, bound into the top module.
// Assumes: it sees the top's ports plus the internal companion-select wire.
module sector_prefetch_seq_chk #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              miss_valid,
    input logic              miss_ready,
    input logic              hi_prio_pending,
    input logic              companion_hit,
    input logic              addr_hold,
    input logic              backoff,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_pipelined,
    input logic              comp_sel
);
    localparam int OFS_W = $clog2(LINE_BYTES);

    // R2: every request address is line-aligned
    a_r2_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_addr[OFS_W-1:0] == '0));

    // R5: no request under address hold or back-off
    a_r5_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_hold || backoff) |-> !req_valid);

    // R6: the companion yields to higher-priority traffic
    a_r6_prio_yield: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_prio_pending && comp_sel) |-> !req_valid);

    // R7: a pipelined request is always a companion
    a_r7_pipe_is_comp: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_pipelined) |-> comp_sel);

    // R9: a present companion line is never requested
    a_r9_hit_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (companion_hit && comp_sel) |-> !req_valid);

    // R10: accepting a miss never coincides with a request
    a_r10_miss_first: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && miss_ready) |-> !req_valid);
endmodule

bind sector_prefetch_seq sector_prefetch_seq_chk #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .miss_valid     (miss_valid),
    .miss_ready     (miss_ready),
    .hi_prio_pending(hi_prio_pending),
    .companion_hit  (companion_hit),
    .addr_hold      (addr_hold),
    .backoff        (backoff),
    .req_valid      (req_valid),
    .req_addr       (req_addr),
    .req_pipelined  (req_pipelined),
    .comp_sel       (comp_sel)
);

// File: tb/tb_sector_prefetch_seq.sv
// Directed bench: one task per scenario, each checking its own results.
// Inputs change just after the falling edge and outputs are sampled 1 ns later.
module tb_sector_prefetch_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        miss_valid = 1'b0, miss_sw = 1'b0;
    logic [31:0] miss_addr = '0;
    logic        miss_ready;
    logic        hi_prio_pending = 1'b0, companion_hit = 1'b0;
    logic [31:0] probe_addr;
    logic        addr_hold = 1'b0, backoff = 1'b0, next_addr = 1'b0;
    logic        req_valid, req_pipelined;
    logic        req_ready = 1'b0;
    logic [31:0] req_addr;
    logic        burst_done = 1'b0;
    logic        fill_done, fill_companion;
    int          errors = 0, checks = 0;

    always #10 clk = ~clk;  // 50 MHz

    sector_prefetch_seq dut (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, tag, act, exp);
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    // Offer a miss for one cycle; it returns with the block in the demand-request state.
    task automatic issue_miss(input logic [31:0] a, input logic sw);
        @(negedge clk);
        miss_valid = 1'b1; miss_addr = a; miss_sw = sw;
        #1;
        chk_eq("R1 miss_ready when idle", {31'b0, miss_ready}, 32'd1);
        @(negedge clk);
        miss_valid = 1'b0;
        #1;
    endtask

    task automatic handshake();
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        #1;
    endtask

    task automatic done_pulse(input logic exp_comp);
        burst_done = 1'b1;
        #1;
        chk_eq("R11 fill_done pulse", {31'b0, fill_done}, 32'd1);
        chk_eq("R11 fill_companion", {31'b0, fill_companion}, {31'b0, exp_comp});
        @(negedge clk);
        burst_done = 1'b0;
        #1;
        chk_eq("R11 fill_done single", {31'b0, fill_done}, 32'd0);
    endtask

    task automatic test_reset();
        chk_eq("R1 req_valid reset", {31'b0, req_valid}, 32'd0);
        chk_eq("R1 miss_ready reset", {31'b0, miss_ready}, 32'd1);
        chk_eq("R1 fill_done reset", {31'b0, fill_done}, 32'd0);
    endtask

    task automatic test_hw_pair();
        issue_miss(32'h0001_2345, 1'b0);
        chk_eq("R2 demand valid", {31'b0, req_valid}, 32'd1);
        chk_eq("R2 demand addr", req_addr, 32'h0001_2340);
        chk_eq("R2 demand not pipelined", {31'b0, req_pipelined}, 32'd0);
        handshake();
        for (int i = 0; i < 3; i++) begin
            chk_eq("R8 no companion before done", {31'b0, req_valid}, 32'd0);
            tick();
        end
        done_pulse(1'b0);
        chk_eq("R3 companion valid", {31'b0, req_valid}, 32'd1);
        chk_eq("R3 companion addr", req_addr, 32'h0001_2360);
        chk_eq("R3 companion not pipelined", {31'b0, req_pipelined}, 32'd0);
        handshake();
        done_pulse(1'b1);
        chk_eq("R3 idle after pair", {31'b0, miss_ready}, 32'd1);
    endtask

    task automatic test_sw_single();
        issue_miss(32'h0000_0F7F, 1'b1);
        chk_eq("R4 sw demand addr", req_addr, 32'h0000_0F60);
        handshake();
        done_pulse(1'b0);
        for (int i = 0; i < 3; i++) begin
            chk_eq("R4 no companion for sw", {31'b0, req_valid}, 32'd0);
            chk_eq("R4 back to idle", {31'b0, miss_ready}, 32'd1);
            tick();
        end
    endtask

    task automatic test_pipelined();
        issue_miss(32'h0000_0100, 1'b0);
        handshake();
        next_addr = 1'b1;
        tick();
        next_addr = 1'b0;
        #1;
        chk_eq("R7 early companion valid", {31'b0, req_valid}, 32'd1);
        chk_eq("R7 pipelined flag", {31'b0, req_pipelined}, 32'd1);
        chk_eq("R7 companion addr", req_addr, 32'h0000_0120);
        handshake();
        done_pulse(1'b0);
        done_pulse(1'b1);
        chk_eq("R7 idle after pair", {31'b0, miss_ready}, 32'd1);
    endtask

    task automatic test_holds();
        issue_miss(32'h0000_2000, 1'b0);
        hi_prio_pending = 1'b1; #1;
        chk_eq("R6 demand ignores priority", {31'b0, req_valid}, 32'd1);
        hi_prio_pending = 1'b0; addr_hold = 1'b1; #1;
        chk_eq("R5 hold blocks demand", {31'b0, req_valid}, 32'd0);
        tick();
        chk_eq("R5 hold still blocks", {31'b0, req_valid}, 32'd0);
        addr_hold = 1'b0; backoff = 1'b1; #1;
        chk_eq("R5 backoff blocks demand", {31'b0, req_valid}, 32'd0);
        backoff = 1'b0; #1;
        chk_eq("R5 released", {31'b0, req_valid}, 32'd1);
        handshake();
        done_pulse(1'b0);
        addr_hold = 1'b1; #1;
        chk_eq("R5 hold blocks companion", {31'b0, req_valid}, 32'd0);
        addr_hold = 1'b0; hi_prio_pending = 1'b1; #1;
        chk_eq("R6 priority blocks companion", {31'b0, req_valid}, 32'd0);
        tick();
        chk_eq("R6 priority still blocks", {31'b0, req_valid}, 32'd0);
        hi_prio_pending = 1'b0; #1;
        chk_eq("R6 companion resumes", {31'b0, req_valid}, 32'd1);
        chk_eq("R6 companion addr", req_addr, 32'h0000_2020);
        handshake();
        done_pulse(1'b1);
    endtask

    task automatic test_hit_drop();
        issue_miss(32'h0000_3000, 1'b0);
        handshake();
        done_pulse(1'b0);
        chk_eq("R9 probe addr", probe_addr, 32'h0000_3020);
        companion_hit = 1'b1; #1;
        chk_eq("R9 hit blocks companion", {31'b0, req_valid}, 32'd0);
        tick();
        companion_hit = 1'b0; #1;
        for (int i = 0; i < 3; i++) begin
            chk_eq("R9 companion dropped", {31'b0, req_valid}, 32'd0);
            chk_eq("R9 idle after drop", {31'b0, miss_ready}, 32'd1);
            tick();
        end
    endtask

    task automatic test_new_miss();
        issue_miss(32'h0000_4000, 1'b0);
        handshake();
        done_pulse(1'b0);
        miss_valid = 1'b1; miss_addr = 32'h0000_5047; miss_sw = 1'b1; #1;
        chk_eq("R10 new miss accepted", {31'b0, miss_ready}, 32'd1);
        chk_eq("R10 companion withheld", {31'b0, req_valid}, 32'd0);
        tick();
        miss_valid = 1'b0; #1;
        chk_eq("R10 new demand valid", {31'b0, req_valid}, 32'd1);
        chk_eq("R10 new demand addr", req_addr, 32'h0000_5040);
        handshake();
        done_pulse(1'b0);
        chk_eq("R10 old companion gone", {31'b0, req_valid}, 32'd0);
        chk_eq("R10 idle", {31'b0, miss_ready}, 32'd1);
    endtask

    initial begin : watchdog
        #(20 * 100000);
        errors++; checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        test_reset();
        test_hw_pair();
        test_sw_single();
        test_pipelined();
        test_holds();
        test_hit_drop();
        test_new_miss();
        tick();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule